// File: doc/BRIEF.md
# Windowed Threshold Persistence Interrupt

This block watches the stream of finished light measurements from a sensor front end and decides when the host should be interrupted. Each measurement arrives as a 16-bit channel-0 count together with a one-cycle valid pulse at the end of an integration period. The count is compared against a programmable low and high limit. A run counter tracks how many measurements in a row have fallen outside that window. The interrupt is raised once the run reaches the length selected by a 4-bit persistence code.

Once raised, the interrupt is held until the host issues a one-cycle clear. The held state is always visible on a status output. The active-low pin output follows that state only while the pin enable is set, so software can poll with the pin masked. Limits and persistence code are sampled at the moment each measurement is evaluated, so a change takes effect with the next valid pulse.

Top module: `win_persist_irq`

## Requirements
- R1: After reset the status output is 0 and the pin output is 1 (deasserted).
- R2: A measurement counts as out of range only when it is strictly below the low limit or strictly above the high limit. A value equal to either limit is in range.
- R3: With persistence code 0 every valid measurement raises the interrupt, in range or not.
- R4: Codes 1, 2 and 3 raise the interrupt on the 1st, 2nd and 3rd consecutive out-of-range measurement respectively.
- R5: Codes 4 to 15 need 5 × (code − 3) consecutive out-of-range measurements (5, 10, ... 60).
- R6: An in-range measurement restarts the run from zero. Out-of-range measurements separated by it do not add up.
- R7: Once raised, the status stays 1 in every following cycle until a clear pulse, whatever measurements arrive.
- R8: A clear pulse drops the status in the next cycle and restarts the run. When a measurement arrives in the same cycle as the clear, the status still drops, and that measurement is counted as the first of a new run.
- R9: The status output does not depend on the pin enable. The pin output is 0 exactly while the status is 1 and the enable is 1.
- R10: Limits and persistence code are taken as they stand in the cycle of the valid pulse. A change made in that same cycle applies to that measurement.
- R11: The status output changes one clock after the valid or clear pulse that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | One-cycle pulse marking a finished measurement |
| meas_val | input | DATA_W | Channel-0 measurement count |
| lim_lo | input | DATA_W | Low window limit |
| lim_hi | input | DATA_W | High window limit |
| pers_code | input | CODE_W | Persistence code |
| pin_en | input | 1 | Lets the held interrupt reach the pin |
| irq_clr | input | 1 | One-cycle clear of the held interrupt and run |
| irq_status | output | 1 | Held interrupt state |
| irq_pin_n | output | 1 | Interrupt pin, active low |

## Verification
The bench probes the window edges with values at the limits and one count beyond each. A design that used non-strict compares would trip on the limit values. It counts exact run lengths at codes 1, 2, 3, 4, 9 and 15, stopping one short and then reaching the target, which exposes an off-by-one run length or a linear code mapping. It breaks runs with an in-range value, which catches a counter that only saturates or holds instead of restarting. It also sends a clear together with an out-of-range measurement and then needs only one more to trip code 2. A design that dropped that measurement would stay quiet, and one that let the sample win over the clear would keep the status high.

// File: rtl/wpi_pkg.sv
package wpi_pkg;

   // Required run length for a persistence code: codes up to lin map
   // one-to-one, codes above step by 'step' per code.
   function automatic int unsigned wpi_run_len(input int unsigned code,
                                               input int unsigned lin,
                                               input int unsigned step);
      if (code <= lin)
         return code;
      return (code - lin) * step;
   endfunction

endpackage

// File: rtl/wpi_window_cmp.sv
module wpi_window_cmp #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] val,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   output logic              outside
);

   logic below_lo;
   logic above_hi;

   assign below_lo = (val < lo);
   assign above_hi = (val > hi);
   assign outside  = below_lo | above_hi;

   // R2: a value sitting on either limit is never reported as outside
   always_comb begin
      if (val == lo && lo <= hi) begin
         p_edge_lo_r2: assert (!outside);
      end
      if (val == hi && lo <= hi) begin
         p_edge_hi_r2: assert (!outside);
      end
   end

endmodule

// File: rtl/wpi_run_decode.sv
module wpi_run_decode
   import wpi_pkg::*;
#(
   parameter int CODE_W = 4,
   parameter int LINEAR = 3,
   parameter int STEP   = 5,
   parameter int CNT_W  = 6
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  need
);

   localparam int N_CODES = 2 ** CODE_W;

   logic [CNT_W-1:0] len_tbl [N_CODES];

   for (genvar g = 0; g < N_CODES; g++) begin : g_tbl
      assign len_tbl[g] = CNT_W'(wpi_run_len(g, LINEAR, STEP));
   end

   assign need = len_tbl[code];

endmodule

// File: rtl/wpi_persist_core.sv
module wpi_persist_core #(
   parameter int CNT_W   = 6,
   parameter int MAX_RUN = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             outside,
   input  logic [CNT_W-1:0] need,
   input  logic             clr,
   output logic             held
);

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_base;
   logic [CNT_W-1:0] run_d;
   logic             trip;
   logic             held_d;

   always_comb begin
      run_base = clr ? '0 : run_q;
      run_d    = run_base;
      trip     = 1'b0;
      if (valid) begin
         if (outside) begin
            run_d = (run_base >= need) ? need : run_base + CNT_W'(1);
         end else begin
            run_d = '0;
         end
         trip = (need == '0) || (outside && run_d >= need);
      end
      held_d = clr ? 1'b0 : (held | trip);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         held  <= 1'b0;
      end else begin
         run_q <= run_d;
         held  <= held_d;
      end
   end

   // R7: held state survives any cycle without a clear
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      held && !clr |=> held);

   // R8: clear always drops the held state next cycle
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !held);

   // R3: code 0 trips on every measurement
   p_code0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !clr && need == '0 |=> held);

   // R6: an in-range measurement restarts the run
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !outside |=> run_q == '0);

   // R4: the run never climbs past the longest run length
   p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= CNT_W'(MAX_RUN));

endmodule

// File: rtl/win_persist_irq.sv
module win_persist_irq
   import wpi_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CODE_W       = 4,
   parameter int LINEAR_CODES = 3,
   parameter int RUN_STEP     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              meas_valid,
   input  logic [DATA_W-1:0] meas_val,
   input  logic [DATA_W-1:0] lim_lo,
   input  logic [DATA_W-1:0] lim_hi,
   input  logic [CODE_W-1:0] pers_code,
   input  logic              pin_en,
   input  logic              irq_clr,
   output logic              irq_status,
   output logic              irq_pin_n
);

   localparam int TOP_CODE = (2 ** CODE_W) - 1;
   localparam int MAX_RUN  = int'(wpi_run_len(TOP_CODE, LINEAR_CODES, RUN_STEP));
   localparam int CNT_W    = (MAX_RUN < 1) ? 1 : $clog2(MAX_RUN + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (LINEAR_CODES >= 2 ** CODE_W) begin : g_bad_linear
      $error("LINEAR_CODES must leave room for stepped codes");
   end
   if (RUN_STEP < 1) begin : g_bad_step
      $error("RUN_STEP must be positive");
   end

   logic             outside;
   logic [CNT_W-1:0] need;
   logic             held;

   wpi_window_cmp #(.DATA_W(DATA_W)) i_cmp (
      .val     (meas_val),
      .lo      (lim_lo),
      .hi      (lim_hi),
      .outside (outside)
   );

   wpi_run_decode #(
      .CODE_W (CODE_W),
      .LINEAR (LINEAR_CODES),
      .STEP   (RUN_STEP),
      .CNT_W  (CNT_W)
   ) i_dec (
      .code (pers_code),
      .need (need)
   );

   wpi_persist_core #(
      .CNT_W   (CNT_W),
      .MAX_RUN (MAX_RUN)
   ) i_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (meas_valid),
      .outside (outside),
      .need    (need),
      .clr     (irq_clr),
      .held    (held)
   );

   assign irq_status = held;
   assign irq_pin_n  = ~(held & pin_en);

   // R9: the pin can only be low while the enable is set
   p_pin_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_pin_n |-> pin_en);

   // R11: status only rises after a valid pulse
   p_rise_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status) |-> $past(meas_valid));

   // R11: status only falls after a clear pulse
   p_fall_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_status) |-> $past(irq_clr));

endmodule

// File: tb/test_win_persist_irq.sv
`timescale 1ns/1ps
module test_win_persist_irq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        meas_valid = 1'b0;
   logic [15:0] meas_val = '0;
   logic [15:0] lim_lo = '0;
   logic [15:0] lim_hi = '0;
   logic [3:0]  pers_code = '0;
   logic        pin_en = 1'b0;
   logic        irq_clr = 1'b0;
   logic        irq_status;
   logic        irq_pin_n;

   int n_chk = 0;
   int n_bad = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   // behavioural reference state
   int m_run = 0;
   int m_held = 0;

   always #5 clk = ~clk;

   win_persist_irq i_win_persist_irq (
      .clk, .rst_n, .meas_valid, .meas_val, .lim_lo, .lim_hi,
      .pers_code, .pin_en, .irq_clr, .irq_status, .irq_pin_n
   );

   function automatic int run_needed(input int code);
      if (code <= 3) return code;
      return (code - 3) * 5;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run  = 0;
         m_held = 0;
      end else begin
         int base;
         int need;
         int hit;
         bit outside;
         need    = run_needed(int'(pers_code));
         outside = (meas_val < lim_lo) || (meas_val > lim_hi);
         base    = irq_clr ? 0 : m_run;
         hit     = 0;
         if (meas_valid) begin
            if (outside) base = (base + 1 > need) ? need : base + 1;
            else         base = 0;
            hit = (need == 0) || (outside && base >= need);
         end
         m_run  = base;
         m_held = irq_clr ? 0 : ((m_held != 0 || hit != 0) ? 1 : 0);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_cmp();
      int exp_pin;
      exp_pin = (m_held != 0 && pin_en) ? 0 : 1;
      check({cur_req, " model status"}, int'(irq_status), m_held);
      check({cur_req, " model pin"}, int'(irq_pin_n), exp_pin);
   endtask

   // one cycle: drive at a falling edge, compare at the next one
   task automatic step(input bit v, input int s, input bit c);
      meas_valid = v;
      meas_val   = 16'(s);
      irq_clr    = c;
      @(negedge clk);
      model_cmp();
      meas_valid = 1'b0;
      irq_clr    = 1'b0;
   endtask

   task automatic clear();
      step(1'b0, 0, 1'b1);
   endtask

   task automatic runs(input int n, input int s);
      for (int i = 0; i < n; i++) step(1'b1, s, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      lim_lo = 16'd100;
      lim_hi = 16'd200;
      pin_en = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 status", int'(irq_status), 0);
      check("R1 pin", int'(irq_pin_n), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status after release", int'(irq_status), 0);

      // R2: limits are inclusive, one beyond trips
      cur_req = "R2";
      pers_code = 4'd1;
      step(1'b1, 100, 1'b0);
      step(1'b1, 200, 1'b0);
      check("R2 on limits", int'(irq_status), 0);
      step(1'b1, 99, 1'b0);
      check("R2 below low", int'(irq_status), 1);
      check("R2 pin low", int'(irq_pin_n), 0);
      clear();
      check("R8 clear drops", int'(irq_status), 0);
      step(1'b1, 201, 1'b0);
      check("R2 above high", int'(irq_status), 1);
      clear();

      // R3: code 0 trips on in-range data
      cur_req = "R3";
      pers_code = 4'd0;
      step(1'b1, 150, 1'b0);
      check("R3 in-range trips", int'(irq_status), 1);
      clear();
      step(1'b0, 150, 1'b0);
      check("R3 no pulse no trip", int'(irq_status), 0);

      // R4: short codes
      cur_req = "R4";
      pers_code = 4'd3;
      runs(2, 5);
      check("R4 code3 after 2", int'(irq_status), 0);
      runs(1, 5);
      check("R4 code3 after 3", int'(irq_status), 1);
      clear();
      pers_code = 4'd2;
      runs(1, 500);
      check("R4 code2 after 1", int'(irq_status), 0);
      runs(1, 500);
      check("R4 code2 after 2", int'(irq_status), 1);
      clear();

      // R6: in-range value breaks the run
      cur_req = "R6";
      step(1'b1, 5, 1'b0);
      step(1'b1, 150, 1'b0);
      step(1'b1, 5, 1'b0);
      check("R6 broken run", int'(irq_status), 0);
      step(1'b1, 5, 1'b0);
      check("R6 fresh run", int'(irq_status), 1);
      clear();

      // R5: stepped codes
      cur_req = "R5";
      pers_code = 4'd4;
      runs(4, 5);
      check("R5 code4 after 4", int'(irq_status), 0);
      runs(1, 5);
      check("R5 code4 after 5", int'(irq_status), 1);
      clear();
      pers_code = 4'd9;
      runs(29, 900);
      check("R5 code9 after 29", int'(irq_status), 0);
      runs(1, 900);
      check("R5 code9 after 30", int'(irq_status), 1);
      clear();
      pers_code = 4'd15;
      runs(59, 5);
      check("R5 code15 after 59", int'(irq_status), 0);
      runs(1, 5);
      check("R5 code15 after 60", int'(irq_status), 1);

      // R7: held through in-range data and idle cycles
      cur_req = "R7";
      runs(5, 150);
      step(1'b0, 0, 1'b0);
      check("R7 held", int'(irq_status), 1);

      // R8: clear with a coincident sample
      cur_req = "R8";
      pers_code = 4'd2;
      step(1'b1, 5, 1'b1);
      check("R8 clear wins", int'(irq_status), 0);
      step(1'b1, 5, 1'b0);
      check("R8 coincident sample counted", int'(irq_status), 1);
      clear();

      // R9: enable masks the pin only
      cur_req = "R9";
      pin_en = 1'b0;
      pers_code = 4'd1;
      step(1'b1, 5, 1'b0);
      check("R9 status unmasked", int'(irq_status), 1);
      check("R9 pin masked", int'(irq_pin_n), 1);
      pin_en = 1'b1;
      #1;
      check("R9 pin enabled", int'(irq_pin_n), 0);
      clear();

      // R10: settings changed in the sample cycle apply at once
      cur_req = "R10";
      pers_code = 4'd1;
      lim_lo = 16'd160;
      step(1'b1, 150, 1'b0);
      check("R10 new low limit", int'(irq_status), 1);
      clear();
      lim_lo = 16'd100;
      pers_code = 4'd0;
      step(1'b1, 150, 1'b0);
      check("R10 new code", int'(irq_status), 1);
      clear();

      // R11: one-cycle latency of rise
      cur_req = "R11";
      pers_code = 4'd1;
      meas_valid = 1'b1;
      meas_val = 16'd5;
      @(posedge clk);
      #1;
      meas_valid = 1'b0;
      check("R11 rises after edge", int'(irq_status), 1);
      @(negedge clk);
      clear();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule